// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is an up-counting timer with two compare registers, called A and P, and one output pin. A mode field selects one of two running behaviours. In the plain timer behaviour the block only raises match flags. In the pulse-width behaviour one comparator resets the count, which fixes the period, and the other comparator sets how long the pin stays active within each period. A swap bit picks which comparator does which job. The counter advances only on cycles where the clock-enable input is high, so a prescaler in front of the block sets the time base.

Software writes three words through a small write port: a control word at address 0, compare A at address 1 and compare P at address 2. New compare values go into pending copies. The pending copies move into the comparators at the next period boundary, so a running waveform never shows a partial period. Each comparator has its own sticky flag, and a write-one-to-clear input clears it.

Top module: `dual_cmp_pwm_timer`

## Requirements
- R1: After synchronous reset the counter, both flags, `pin_out` and `pin_oe` are 0. The control word is 0 (idle mode), and both compare values, pending and active, are 0.
- R2: Control bits [1:0] = 2'b11 selects timer mode. In timer mode `pin_oe` and `pin_out` are 0 one cycle later, while the flags behave as in any running mode.
- R3: Control bits [1:0] = 2'b10 selects PWM mode. `pin_oe` is 1 one cycle after PWM mode is entered. With output control bits [3:2] = 2'b10, the registered waveform appears on `pin_out`, one cycle behind the count it was derived from.
- R4: With swap bit [6] = 0 in PWM mode, the counter returns to 0 on the enabled cycle after it equals compare P, so the period is P+1 enabled cycles. Compare A is the duty value.
- R5: With swap bit [6] = 1 in PWM mode, compare A sets the period in the same way and compare P is the duty value.
- R6: Output control 2'b00 holds `pin_out` at 0 and 2'b01 holds it at 1; 2'b11 also gives 0. In all of these cases the counter and flags keep running, so the waveform returns in phase when 2'b10 is restored.
- R7: Bit [7] picks the clearing comparator in timer mode only: 0 means P clears the counter and 1 means A clears it. In PWM mode bit [7] has no effect.
- R8: The waveform is active while the count is below the duty value. Bit [4] gives the active level. Bit [5] then inverts the waveform driven on the pin, but it does not invert the forced levels.
- R9: A duty value of 0 gives a constantly inactive waveform. A nonzero duty value equal to or above the period value gives a constantly active waveform.
- R10: An enabled cycle whose count equals compare A sets `flag_a`, and the same holds for P and `flag_p`. A flag stays set until its `flag_clr` bit (bit 0 for A, bit 1 for P) is 1. A new match in the same cycle wins over the clear.
- R11: Written compare values become active at a period boundary, meaning an enabled cycle that clears the counter or wraps it from all-ones. In idle mode they become active on the next cycle.
- R12: On cycles where `tick` is 0, the counter holds its value and no flag is set.
- R13: Modes 2'b00 and 2'b01 are idle modes. In idle mode the counter is held at 0, no flag is set and `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 compare A, 2 compare P, 3 unused |
| wr_data | input | CNT_W | Write data; control uses bits [7:0] |
| flag_clr | input | 2 | Write-one-to-clear for the flags (bit 0 A, bit 1 P) |
| pin_out | output | 1 | Registered pin level |
| pin_oe | output | 1 | Pin drive enable, high in PWM mode |
| flag_a | output | 1 | Sticky match flag of comparator A |
| flag_p | output | 1 | Sticky match flag of comparator P |

## Verification
The assertions assume that the control word only holds the codes listed above. They also assume that the counter moves only through enable-gated steps, so a check such as "no enable means no change" is meaningful on every cycle. The stimulus writes only encoded control words and changes inputs only at falling edges. It keeps the compare values small, so that many periods, boundaries and flag events fit into each phase. A reference model in the bench follows the requirements edge by edge, and a monitor compares each cycle's outputs against it.

// File: rtl/dcpt_pkg.sv
package dcpt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF0 = 2'b00,
    MODE_OFF1 = 2'b01,
    MODE_PWM  = 2'b10,
    MODE_TMR  = 2'b11
  } mode_e;

  typedef struct packed {
    logic       cclr;    // timer-mode clear select: 1 = A, 0 = P
    logic       swap;    // PWM role swap: 1 = A is period
    logic       pol;     // inverts the waveform on the pin
    logic       act_lvl; // level of the active part
    logic [1:0] oc;      // output control
    mode_e      mode;
  } ctrl_t;

  localparam int CTRL_W = 8;
endpackage

// File: rtl/dcpt_regs.sv
module dcpt_regs
  import dcpt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output ctrl_t        ctrl_o,
  output logic [W-1:0] cmp_a_o,
  output logic [W-1:0] cmp_p_o
);
  ctrl_t        ctrl_q;
  logic [W-1:0] pend_a_q, pend_p_q, act_a_q, act_p_q;
  logic         unused_hi;

  assign unused_hi = ^wr_data[W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      pend_a_q <= '0;
      pend_p_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        2'd1:    pend_a_q <= wr_data;
        2'd2:    pend_p_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_a_q <= '0;
      act_p_q <= '0;
    end else if (load) begin
      act_a_q <= pend_a_q;
      act_p_q <= pend_p_q;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign cmp_a_o = act_a_q;
  assign cmp_p_o = act_p_q;

  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_a_q) && $stable(act_p_q)));
endmodule

// File: rtl/dcpt_core.sv
module dcpt_core
  import dcpt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  ctrl_t        ctrl,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_p,
  input  logic [1:0]   flag_clr,
  output logic [W-1:0] cnt_o,
  output logic         boundary_o,
  output logic         flag_a_o,
  output logic         flag_p_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic         fa_q, fp_q;
  logic         run, pwm, step, hit_a, hit_p, clr_by_a, per_hit;

  assign run      = ctrl.mode[1];
  assign pwm      = (ctrl.mode == MODE_PWM);
  assign step     = run & tick;
  assign hit_a    = (cnt_q == cmp_a);
  assign hit_p    = (cnt_q == cmp_p);
  assign clr_by_a = pwm ? ctrl.swap : ctrl.cclr;
  assign per_hit  = clr_by_a ? hit_a : hit_p;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= per_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q <= 1'b0;
      fp_q <= 1'b0;
    end else begin
      fa_q <= (fa_q & ~flag_clr[0]) | (step & hit_a);
      fp_q <= (fp_q & ~flag_clr[1]) | (step & hit_p);
    end
  end

  assign boundary_o = step & (per_hit | (cnt_q == CNT_MAX));
  assign cnt_o      = cnt_q;
  assign flag_a_o   = fa_q;
  assign flag_p_o   = fp_q;

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fa_q && !flag_clr[0]) |=> fa_q);
endmodule

// File: rtl/dcpt_outstage.sv
module dcpt_outstage
  import dcpt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_t        ctrl,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_p,
  output logic         pin_out,
  output logic         pin_oe
);
  logic [W-1:0] per, duty;
  logic         in_duty, wave, pwm;

  assign pwm     = (ctrl.mode == MODE_PWM);
  assign per     = ctrl.swap ? cmp_a : cmp_p;
  assign duty    = ctrl.swap ? cmp_p : cmp_a;
  assign in_duty = (duty != '0) && ((cnt < duty) || (duty >= per));
  assign wave    = (in_duty ? ctrl.act_lvl : ~ctrl.act_lvl) ^ ctrl.pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_oe <= pwm;
      if (!pwm)                 pin_out <= 1'b0;
      else if (ctrl.oc == 2'b10) pin_out <= wave;
      else if (ctrl.oc == 2'b01) pin_out <= 1'b1;
      else                      pin_out <= 1'b0;
    end
  end

  // R2
  oe_timer_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode == MODE_TMR) |=> (!pin_oe && !pin_out));
  // R6
  forced_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm && ctrl.oc == 2'b01) |=> (pin_out && pin_oe));
endmodule

// File: rtl/dual_cmp_pwm_timer.sv
module dual_cmp_pwm_timer
  import dcpt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       flag_clr,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             flag_a,
  output logic             flag_p
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp_a, cmp_p, cnt;
  logic             boundary, load;

  assign load = boundary | ~ctrl.mode[1];

  dcpt_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .ctrl_o(ctrl),
    .cmp_a_o(cmp_a), .cmp_p_o(cmp_p)
  );

  dcpt_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .ctrl(ctrl),
    .cmp_a(cmp_a), .cmp_p(cmp_p), .flag_clr(flag_clr),
    .cnt_o(cnt), .boundary_o(boundary),
    .flag_a_o(flag_a), .flag_p_o(flag_p)
  );

  dcpt_outstage #(.W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .ctrl(ctrl), .cnt(cnt),
    .cmp_a(cmp_a), .cmp_p(cmp_p),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: tb/dual_cmp_pwm_timer_test.sv
module dual_cmp_pwm_timer_test;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   flag_clr = '0;
  logic         pin_out, pin_oe, flag_a, flag_p;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  logic [3:0] expq[$];
  bit tick_rand = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  always #2 clk = ~clk;

  dual_cmp_pwm_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flag_clr(flag_clr), .pin_out(pin_out),
    .pin_oe(pin_oe), .flag_a(flag_a), .flag_p(flag_p)
  );

  // reference model from the requirements
  logic [W-1:0] m_cnt, m_a, m_p, m_pa, m_pp;
  logic [7:0]   m_ctl;
  logic         m_fa, m_fp, m_out, m_oe;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_a = '0; m_p = '0; m_pa = '0; m_pp = '0;
      m_ctl = '0; m_fa = 0; m_fp = 0; m_out = 0; m_oe = 0;
    end else begin
      logic run, pwm, ha, hp, clra, ph, bnd, ind;
      logic [W-1:0] per, duty;
      run  = m_ctl[1];
      pwm  = (m_ctl[1:0] == 2'b10);
      ha   = (m_cnt == m_a);
      hp   = (m_cnt == m_p);
      clra = pwm ? m_ctl[6] : m_ctl[7];
      ph   = clra ? ha : hp;
      per  = m_ctl[6] ? m_a : m_p;
      duty = m_ctl[6] ? m_p : m_a;
      ind  = (duty != 0) && ((m_cnt < duty) || (duty >= per));
      m_oe = pwm;
      if (!pwm) m_out = 0;
      else if (m_ctl[3:2] == 2'b10) m_out = (ind ? m_ctl[4] : ~m_ctl[4]) ^ m_ctl[5];
      else m_out = (m_ctl[3:2] == 2'b01);
      m_fa = (m_fa & ~flag_clr[0]) | (run & tick & ha);
      m_fp = (m_fp & ~flag_clr[1]) | (run & tick & hp);
      bnd  = run & tick & (ph | (m_cnt == '1));
      if (bnd || !run) begin m_a = m_pa; m_p = m_pp; end
      if (!run) m_cnt = '0;
      else if (tick) m_cnt = ph ? '0 : m_cnt + 1'b1;
      if (wr_en) begin
        if (wr_addr == 2'd0) m_ctl = wr_data[7:0];
        else if (wr_addr == 2'd1) m_pa = wr_data;
        else if (wr_addr == 2'd2) m_pp = wr_data;
      end
    end
    expq.push_back({m_out, m_oe, m_fa, m_fp});
  end

  // monitor
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [3:0] e, a;
      e = expq.pop_front();
      a = {pin_out, pin_oe, flag_a, flag_p};
      vectors++;
      if (a !== e) begin
        miscompares++;
        $display("FAIL %s t=%0t {out,oe,fa,fp} actual=%b expected=%b", cur_req, $time, a, e);
      end
    end
    if (tick_rand) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick = lfsr[0];
    end
  end

  function automatic logic [W-1:0] cw(input logic [1:0] md, input logic [1:0] oc,
      input logic act, input logic pl, input logic sw, input logic cc);
    return W'({cc, sw, pl, act, oc, md});
  endfunction

  task automatic wr(input logic [1:0] ad, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr(input logic [1:0] c);
    @(negedge clk);
    flag_clr = c;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  initial begin
    cur_req = "R1";
    cyc(4);
    @(negedge clk);
    rst = 1'b0;
    vectors++;
    if ({pin_out, pin_oe, flag_a, flag_p} !== 4'b0000) begin
      miscompares++;
      $display("FAIL R1 reset outputs actual=%b expected=0000", {pin_out, pin_oe, flag_a, flag_p});
    end
    cur_req = "R13 R11 idle load";
    wr(2'd1, 10'd3);
    wr(2'd2, 10'd7);
    cyc(6);
    cur_req = "R3 R4 pwm swap0";
    wr(2'd0, cw(2'b10, 2'b10, 1, 0, 0, 0));
    cyc(40);
    cur_req = "R7 cclr ignored in pwm";
    wr(2'd0, cw(2'b10, 2'b10, 1, 0, 0, 1));
    cyc(25);
    cur_req = "R11 R5 R9 swap with update";
    wr(2'd2, 10'd2);
    wr(2'd0, cw(2'b10, 2'b10, 1, 0, 1, 0));
    cyc(30);
    wr(2'd2, 10'd5);
    cyc(30);
    cur_req = "R6 forced low";
    wr(2'd0, cw(2'b10, 2'b00, 1, 0, 1, 0));
    cyc(15);
    cur_req = "R6 forced high";
    wr(2'd0, cw(2'b10, 2'b01, 1, 0, 1, 0));
    cyc(15);
    cur_req = "R6 forced 11";
    wr(2'd0, cw(2'b10, 2'b11, 1, 0, 1, 0));
    cyc(7);
    cur_req = "R8 active level and polarity";
    wr(2'd0, cw(2'b10, 2'b10, 0, 0, 0, 0));
    cyc(20);
    wr(2'd0, cw(2'b10, 2'b10, 1, 1, 0, 0));
    cyc(20);
    wr(2'd0, cw(2'b10, 2'b01, 1, 1, 0, 0));
    cyc(8);
    cur_req = "R9 duty zero";
    wr(2'd0, cw(2'b10, 2'b10, 1, 0, 0, 0));
    wr(2'd1, 10'd0);
    cyc(30);
    cur_req = "R9 duty above period";
    wr(2'd1, 10'd9);
    cyc(30);
    cur_req = "R10 flag clear";
    wr(2'd1, 10'd4);
    cyc(12);
    clr(2'b01);
    cyc(3);
    clr(2'b10);
    cyc(3);
    clr(2'b11);
    cyc(10);
    cur_req = "R12 gated tick";
    tick_rand = 1'b1;
    cyc(80);
    clr(2'b11);
    cyc(40);
    tick_rand = 1'b0;
    @(negedge clk);
    tick = 1'b1;
    cur_req = "R2 R7 timer clear by P";
    wr(2'd0, cw(2'b11, 2'b10, 1, 0, 0, 0));
    cyc(30);
    cur_req = "R2 R7 timer clear by A";
    wr(2'd0, cw(2'b11, 2'b10, 1, 0, 1, 1));
    clr(2'b11);
    cyc(30);
    cur_req = "R13 idle";
    wr(2'd0, cw(2'b01, 2'b10, 1, 0, 0, 0));
    clr(2'b11);
    cyc(20);
    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule